// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital controller for a sixteen-input successive-approximation analog-to-digital converter. Software chooses an operating mode, a first channel, a last channel for scans and an interrupt interval, then starts a sequence with either a software start strobe or a hardware trigger. The sequencer issues one request at a time to an abstract converter core, waits for its done strobe, and writes each 10-bit sample into a bank of result registers.

Three modes exist. One-shot converts a single channel once. Scan walks from the first channel up to the last channel once. Loop converts one channel over and over. In the two once-only modes each sample lands in the register of its own channel. In loop mode the samples rotate through a group of 1, 4 or 8 slots, starting at slot 0, and the busy flag stays high until a soft reset. A busy flag, an end-of-conversion flag and a single-cycle interrupt report progress. Software reads the result registers through a plain read port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `eoc`, `irq` and `core_start` are 0, and every result register reads 0.
- R2: A `sw_start` or `hw_start` pulse sampled while idle sets `busy` at the next clock edge. From that same edge `core_start` is high for exactly one cycle, with `core_ch` equal to `cfg_start_ch`.
- R3: One-shot mode is `cfg_mode`=0, and the value 3 behaves the same way. At the edge that samples `core_done`, the sample is written to the result register numbered `core_ch`. At that same edge `busy` falls, `eoc` rises and `irq` is high for one cycle.
- R4: Scan mode is `cfg_mode`=1. Channels are converted from the first channel up to the last channel, wrapping from 15 to 0. Each sample goes to its own channel's register. Completion has the same effect as in R3 and happens only after the last channel's sample.
- R5: Loop mode is `cfg_mode`=2. The next `core_start` is raised in the cycle right after each done, and `busy` stays 1 until a soft reset.
- R6: In loop mode the interval field `cfg_intv` chooses the slot group. The value 0 selects slot 0 only, with `irq` after every conversion. The value 1 selects slots 0 to 3, with `irq` after every 4th conversion. The values 2 and 3 select slots 0 to 7, with `irq` after every 8th conversion. Samples fill the slots in order and wrap to slot 0. `eoc` rises at the same edge as `irq`.
- R7: Start pulses, from either source, that arrive while `busy` is 1 are ignored.
- R8: A `sw_reset` pulse returns the block to idle at the next edge, with `busy` and `eoc` at 0. It writes no result register, and it overrides a start in the same cycle. A later loop run starts again at slot 0.
- R9: An `eoc_rd` pulse clears `eoc` at the next edge. If the flag is being set at that same edge, setting wins.
- R10: A `core_done` strobe that arrives while no conversion is outstanding changes no flag and no result register.
- R11: The mode, channels and interval are captured when a sequence starts. Changes to them during the sequence have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 0 one-shot, 1 scan, 2 loop, 3 one-shot |
| cfg_start_ch | input | 4 | Converted channel, or first channel of a scan |
| cfg_end_ch | input | 4 | Last channel of a scan |
| cfg_intv | input | 2 | Loop interrupt interval: 0 every conversion, 1 every 4, 2 or 3 every 8 |
| sw_start | input | 1 | Software start pulse |
| hw_start | input | 1 | Hardware trigger start pulse |
| sw_reset | input | 1 | Soft reset pulse that aborts the sequence |
| eoc_rd | input | 1 | Software read of the end-of-conversion flag, clears it |
| core_start | output | 1 | Conversion request to the converter core |
| core_ch | output | 4 | Channel to convert |
| core_done | input | 1 | Converter core finished, `core_data` valid |
| core_data | input | 10 | Converted sample |
| rd_sel | input | 4 | Result register to read |
| rd_data | output | 10 | Content of the selected result register |
| busy | output | 1 | Sequence in progress |
| eoc | output | 1 | End-of-conversion flag |
| irq | output | 1 | Completion interrupt, one-cycle pulse |

## Verification
The bench drives several patterns: one-shot runs from both start sources; scans with a plain range, a range that wraps, and a single channel; and loop runs at every interval. Converter latencies of one to three cycles separate the "no gap after done" rule from designs that only look correct when latency is long. Aborts in mid-conversion, starts while busy, stray done strobes and configuration changes made during a sequence show whether the block ignores these inputs or acts on them. Flag read pulses, including ones that arrive while the flag is being set, show which of set and clear takes priority. A behavioural reference model follows every cycle, and result registers are read back to tell channel addressing apart from slot rotation.

// File: rtl/adc_seq_pkg.sv
// Shared types and helpers for the ADC conversion sequencer.
// Assumes: mode and interval encodings are fixed by the register interface.
package adc_seq_pkg;

    // Operating modes as written by software; the value 3 acts as one-shot.
    typedef enum logic [1:0] {
        MODE_ONE  = 2'd0,
        MODE_SCAN = 2'd1,
        MODE_LOOP = 2'd2,
        MODE_RSVD = 2'd3
    } seq_mode_e;

    // Sequencer states: idle, request issue, waiting on the converter.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    // Width of the loop-mode slot pointer (largest group is eight slots).
    localparam int SLOT_W = 3;

    // Index of the last slot in a loop group for a given interval code.
    function automatic logic [SLOT_W-1:0] grp_last_slot(input logic [1:0] intv);
        case (intv)
            2'd0:    grp_last_slot = 3'd0;
            2'd1:    grp_last_slot = 3'd3;
            default: grp_last_slot = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_fsm.sv
// Conversion sequencer: captures configuration on start, issues converter
// requests, tracks the scan channel and the loop slot, and produces the write
// strobe and the group-complete event.
// Assumes: core_done is a one-cycle strobe answering a core_start request;
// CH_W is at least 3 so the loop slots fit in the channel address space.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [CH_W-1:0]  cfg_start_ch,
    input  logic [CH_W-1:0]  cfg_end_ch,
    input  logic [1:0]       cfg_intv,
    input  logic             sw_start,
    input  logic             hw_start,
    input  logic             sw_reset,
    input  logic             core_done,
    output logic             core_start,
    output logic [CH_W-1:0]  core_ch,
    output logic             busy,
    output logic             wr_en,
    output logic [CH_W-1:0]  wr_addr,
    output logic             grp_done
);

    seq_state_e        st_q;
    seq_mode_e         mode_q;
    logic [CH_W-1:0]   ch_q;
    logic [CH_W-1:0]   end_q;
    logic [SLOT_W-1:0] last_q;
    logic [SLOT_W-1:0] slot_q;

    logic is_loop;
    logic is_scan;
    logic scan_more;
    logic any_start;

    // Decode the captured mode and the continuation conditions.
    always_comb begin
        is_loop   = (mode_q == MODE_LOOP);
        is_scan   = (mode_q == MODE_SCAN);
        scan_more = is_scan && (ch_q != end_q);
        any_start = sw_start || hw_start;
    end

    // State, channel and slot registers of the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= MODE_ONE;
            ch_q   <= '0;
            end_q  <= '0;
            last_q <= '0;
            slot_q <= '0;
        end else if (sw_reset) begin
            st_q   <= ST_IDLE;
            slot_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (any_start) begin
                        st_q   <= ST_ISSUE;
                        mode_q <= seq_mode_e'(cfg_mode);
                        ch_q   <= cfg_start_ch;
                        end_q  <= cfg_end_ch;
                        last_q <= grp_last_slot(cfg_intv);
                        slot_q <= '0;
                    end
                end
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (core_done) begin
                        if (is_loop) begin
                            slot_q <= (slot_q == last_q) ? '0 : slot_q + 1'b1;
                            st_q   <= ST_ISSUE;
                        end else if (scan_more) begin
                            ch_q <= ch_q + 1'b1;
                            st_q <= ST_ISSUE;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs toward the converter core and the status flags.
    always_comb begin
        core_start = (st_q == ST_ISSUE);
        core_ch    = ch_q;
        busy       = (st_q != ST_IDLE);
    end

    // Write strobe, target register and group-complete event for a finished sample.
    always_comb begin
        wr_en    = (st_q == ST_WAIT) && core_done && !sw_reset;
        wr_addr  = is_loop ? CH_W'(slot_q) : ch_q;
        grp_done = wr_en && (is_loop ? (slot_q == last_q) : !scan_more);
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R2
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (sw_start || hw_start) && !sw_reset) |=> (busy && core_start && core_ch == $past(cfg_start_ch))); // R2
    AST_LOOP_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_loop && !sw_reset) |=> busy); // R5
    AST_LOOP_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_loop) |=> core_start); // R5
    AST_SLOT_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= last_q); // R6
    AST_RESET_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> !busy); // R8
    AST_CH_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_scan && !sw_reset) |=> $stable(core_ch)); // R11

endmodule

// File: rtl/adc_result_bank.sv
// Result register bank: one write port fed by the sequencer, one
// combinational read port for software.
// Assumes: writes happen at most once per cycle; reset clears all entries.
module adc_result_bank #(
    parameter int CH_W  = 4,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_addr,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_addr,
    output logic [RES_W-1:0] rd_data
);

    localparam int NUM_REG = 1 << CH_W;

    logic [RES_W-1:0] bank_q [NUM_REG];

    // One storage register per entry, written when its address is selected.
    for (genvar g = 0; g < NUM_REG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_en && (wr_addr == CH_W'(g))) begin
                bank_q[g] <= wr_data;
            end
        end
    end

    // Software read-back of the selected entry.
    always_comb begin
        rd_data = bank_q[rd_addr];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bank_q[$past(wr_addr)] == $past(wr_data))); // R3

endmodule

// File: rtl/adc_seq_flags.sv
// End-of-conversion flag and completion interrupt.
// Assumes: grp_done is already suppressed during a soft reset.
module adc_seq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic grp_done,
    input  logic eoc_rd,
    input  logic sw_reset,
    output logic eoc,
    output logic irq
);

    // Flag set by completion, cleared by a read or a soft reset; set beats read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc <= 1'b0;
            irq <= 1'b0;
        end else begin
            irq <= grp_done;
            if (sw_reset) begin
                eoc <= 1'b0;
            end else if (grp_done) begin
                eoc <= 1'b1;
            end else if (eoc_rd) begin
                eoc <= 1'b0;
            end
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R3
    AST_EOC_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eoc); // R6
    AST_EOC_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && eoc_rd && !grp_done) |=> !eoc); // R9
    AST_RESET_CLEARS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!eoc && !irq)); // R8

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the ADC conversion sequencer: ties the sequencer, result bank and
// flag logic together.
// Assumes: a single clock domain; the converter core answers each request
// with one core_done strobe carrying core_data.
module adc_seq_ctrl #(
    parameter int CH_W  = 4,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [CH_W-1:0]  cfg_start_ch,
    input  logic [CH_W-1:0]  cfg_end_ch,
    input  logic [1:0]       cfg_intv,
    input  logic             sw_start,
    input  logic             hw_start,
    input  logic             sw_reset,
    input  logic             eoc_rd,
    output logic             core_start,
    output logic [CH_W-1:0]  core_ch,
    input  logic             core_done,
    input  logic [RES_W-1:0] core_data,
    input  logic [CH_W-1:0]  rd_sel,
    output logic [RES_W-1:0] rd_data,
    output logic             busy,
    output logic             eoc,
    output logic             irq
);

    logic            wr_en;
    logic [CH_W-1:0] wr_addr;
    logic            grp_done;

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode     (cfg_mode),
        .cfg_start_ch (cfg_start_ch),
        .cfg_end_ch   (cfg_end_ch),
        .cfg_intv     (cfg_intv),
        .sw_start     (sw_start),
        .hw_start     (hw_start),
        .sw_reset     (sw_reset),
        .core_done    (core_done),
        .core_start   (core_start),
        .core_ch      (core_ch),
        .busy         (busy),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .grp_done     (grp_done)
    );

    adc_result_bank #(.CH_W(CH_W), .RES_W(RES_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (core_data),
        .rd_addr (rd_sel),
        .rd_data (rd_data)
    );

    adc_seq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .grp_done (grp_done),
        .eoc_rd   (eoc_rd),
        .sw_reset (sw_reset),
        .eoc      (eoc),
        .irq      (irq)
    );

    AST_COMPLETE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cfg_mode != 2'd2 && $past(cfg_mode) != 2'd2 && !busy) |-> eoc); // R3
    AST_STRAY_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && core_done && !sw_start && !hw_start) |=> (!busy && !irq)); // R10

endmodule

// File: tb/adc_seq_ctrl_bench.sv
// Bench: behavioural reference model compared with the outputs on every clock,
// a converter-core stub with adjustable latency, and result read-back checks.
module adc_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [3:0] cfg_start_ch = 4'd0;
    logic [3:0] cfg_end_ch = 4'd0;
    logic [1:0] cfg_intv = 2'd0;
    logic       sw_start = 1'b0, hw_start = 1'b0, sw_reset = 1'b0, eoc_rd = 1'b0;
    logic       core_start;
    logic [3:0] core_ch;
    logic       core_done = 1'b0;
    logic [9:0] core_data = 10'd0;
    logic [3:0] rd_sel = 4'd0;
    logic [9:0] rd_data;
    logic       busy, eoc, irq;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_start_ch(cfg_start_ch),
        .cfg_end_ch(cfg_end_ch), .cfg_intv(cfg_intv), .sw_start(sw_start),
        .hw_start(hw_start), .sw_reset(sw_reset), .eoc_rd(eoc_rd),
        .core_start(core_start), .core_ch(core_ch), .core_done(core_done),
        .core_data(core_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .busy(busy), .eoc(eoc), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string req_tag = "R1";
    bit    finished = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model state
    int m_state = 0;   // 0 idle, 1 request, 2 waiting
    int m_mode = 0, m_ch = 0, m_end = 0, m_grp = 1, m_slot = 0;
    int m_eoc = 0, m_irq = 0;
    int m_bank [16];

    // Model update on every rising edge from the bench-driven inputs.
    always @(posedge clk) begin
        int fin;
        fin = 0;
        m_irq = 0;
        if (!rst_n) begin
            m_state = 0; m_mode = 0; m_ch = 0; m_end = 0; m_grp = 1; m_slot = 0; m_eoc = 0;
            foreach (m_bank[i]) m_bank[i] = 0;
        end else if (sw_reset) begin
            m_state = 0; m_eoc = 0; m_slot = 0;
        end else begin
            if (m_state == 0) begin
                if (sw_start || hw_start) begin
                    m_mode = cfg_mode; m_ch = cfg_start_ch; m_end = cfg_end_ch;
                    m_grp = (cfg_intv == 0) ? 1 : (cfg_intv == 1) ? 4 : 8;
                    m_slot = 0; m_state = 1;
                end
            end else if (m_state == 1) begin
                m_state = 2;
            end else if (core_done) begin
                if (m_mode == 2) begin
                    m_bank[m_slot] = core_data;
                    m_slot = m_slot + 1;
                    if (m_slot == m_grp) begin m_slot = 0; fin = 1; end
                    m_state = 1;
                end else begin
                    m_bank[m_ch] = core_data;
                    if (m_mode == 1 && m_ch != m_end) begin
                        m_ch = (m_ch + 1) % 16; m_state = 1;
                    end else begin
                        m_state = 0; fin = 1;
                    end
                end
            end
            if (fin) begin m_eoc = 1; m_irq = 1; end
            else if (eoc_rd) m_eoc = 0;
        end
    end

    // Compare every output with the model once per cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(req_tag, "busy", busy, (m_state != 0) ? 1 : 0);
            chk(req_tag, "core_start", core_start, (m_state == 1) ? 1 : 0);
            chk(req_tag, "core_ch", core_ch, m_ch);
            chk(req_tag, "eoc", eoc, m_eoc);
            chk(req_tag, "irq", irq, m_irq);
        end
    end

    // Converter core stub with adjustable latency and an injectable stray done.
    int stub_lat = 1;
    int stub_cnt = 0;
    bit stray_req = 1'b0;
    int dval = 100;
    always @(negedge clk) begin
        core_done = 1'b0;
        if (stub_cnt > 0) begin
            stub_cnt--;
            if (stub_cnt == 0) begin
                core_done = 1'b1; core_data = 10'(dval); dval = (dval * 7 + 13) % 1024;
            end
        end else if (stray_req) begin
            core_done = 1'b1; core_data = 10'(dval); dval = (dval * 7 + 13) % 1024;
            stray_req = 1'b0;
        end
        if (core_start) stub_cnt = stub_lat;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: sw_start = 1'b1;
            1: hw_start = 1'b1;
            2: sw_reset = 1'b1;
            default: eoc_rd = 1'b1;
        endcase
        @(negedge clk);
        sw_start = 1'b0; hw_start = 1'b0; sw_reset = 1'b0; eoc_rd = 1'b0;
    endtask

    task automatic setup(input int mode, input int st, input int en, input int intv, input int lat);
        @(negedge clk);
        cfg_mode = 2'(mode); cfg_start_ch = 4'(st); cfg_end_ch = 4'(en);
        cfg_intv = 2'(intv); stub_lat = lat;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while (m_state != 0 && t < 2000) begin @(negedge clk); t++; end
        chk(req_tag, "sequence finished", (m_state == 0) ? 1 : 0, 1);
        tick(2);
    endtask

    task automatic rd_chk(input int idx);
        @(negedge clk);
        rd_sel = 4'(idx);
        #1;
        chk(req_tag, "rd_data", rd_data, m_bank[idx]);
    endtask

    task automatic rd_all();
        for (int i = 0; i < 16; i++) rd_chk(i);
    endtask

    task automatic loop_run(input int intv, input int lat, input int cycles);
        setup(2, 9, 0, intv, lat);
        pulse(0);
        tick(cycles);
        pulse(2);
        tick(lat + 2);
        for (int i = 0; i < 8; i++) rd_chk(i);
    endtask

    initial begin
        tick(3);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        req_tag = "R1";
        chk("R1", "busy", busy, 0);
        chk("R1", "eoc", eoc, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "core_start", core_start, 0);
        rd_all();

        // R2 and R3: one-shot from each start source, including reserved mode 3
        req_tag = "R2";
        setup(0, 5, 0, 0, 1); pulse(0); wait_idle(); rd_chk(5);
        req_tag = "R3";
        setup(0, 12, 0, 0, 3); pulse(1); wait_idle(); rd_chk(12);
        setup(3, 0, 0, 0, 2); pulse(0); wait_idle(); rd_chk(0);

        // R4: scans with a plain range, a wrapping range and a single channel
        req_tag = "R4";
        setup(1, 3, 7, 0, 1); pulse(0); wait_idle();
        setup(1, 14, 1, 0, 2); pulse(1); wait_idle();
        setup(1, 9, 9, 0, 1); pulse(0); wait_idle();
        rd_all();

        // R9: flag read clears, and a read coinciding with completion loses
        req_tag = "R9";
        pulse(3); tick(2);
        setup(0, 6, 0, 0, 1);
        pulse(0);
        @(negedge clk); eoc_rd = 1'b1;
        tick(6); eoc_rd = 1'b0;
        tick(2); pulse(3); tick(2);

        // R5 and R6: loop mode at every interval and several latencies
        req_tag = "R5";
        loop_run(0, 1, 20);
        req_tag = "R6";
        loop_run(1, 1, 30);
        loop_run(2, 2, 60);
        loop_run(3, 1, 40);
        loop_run(1, 3, 25);

        // R8: abort mid-loop, then a fresh loop must restart at slot 0
        req_tag = "R8";
        setup(2, 4, 0, 2, 1); pulse(0); tick(7); pulse(2); tick(4);
        rd_all();
        pulse(0); tick(5); pulse(2); tick(4);
        for (int i = 0; i < 8; i++) rd_chk(i);
        // R8: reset and start in the same cycle
        setup(0, 2, 0, 0, 1);
        @(negedge clk); sw_reset = 1'b1; sw_start = 1'b1;
        @(negedge clk); sw_reset = 1'b0; sw_start = 1'b0;
        tick(3);
        chk("R8", "busy after reset+start", busy, 0);
        // R8: abort a one-shot while waiting, results preserved
        setup(0, 11, 0, 0, 3); pulse(0); tick(1); pulse(2); tick(5); rd_all();

        // R7: starts while busy are ignored
        req_tag = "R7";
        setup(1, 0, 9, 0, 3); pulse(0); tick(4);
        cfg_start_ch = 4'd13; pulse(0); tick(3); pulse(1);
        wait_idle(); rd_all();

        // R10: stray done while idle
        req_tag = "R10";
        @(negedge clk); stray_req = 1'b1;
        tick(4);
        chk("R10", "busy", busy, 0);
        rd_all();

        // R11: configuration changed during a sequence
        req_tag = "R11";
        setup(1, 2, 4, 0, 2); pulse(0); tick(2);
        cfg_end_ch = 4'd10; cfg_mode = 2'd2; cfg_start_ch = 4'd8;
        wait_idle(); rd_all();

        finished = 1'b1;
        tick(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule